// File: doc/BRIEF.md
# Descriptor-Chained XOR Engine Channel

This block is one channel of a memory-to-memory engine that either XORs several source buffers into one destination buffer or copies a single source buffer. Software points the channel at the first descriptor of a linked list and pulses a start command. The channel then walks the list on its own through a word-wide memory master port. For each descriptor it checks that the engine owns it, moves the data one 32-bit word at a time, writes a completion status back into the descriptor, and follows the next pointer. A next pointer of zero ends the run.

Each descriptor is sixteen 32-bit words. The words sit at these byte offsets: 0x00 status, 0x04 a result word the channel ignores, 0x08 command, 0x0C next-descriptor address, 0x10 byte count, 0x14 destination address, 0x18 to 0x34 the eight source addresses (source s at 0x18 + 4s), and 0x38 and 0x3C reserved. The command word selects the operand sources and decides whether finishing the descriptor raises an interrupt. Pause, restart and stop commands let software suspend the channel at a clean word boundary or abandon the current work. Events are latched in an interrupt cause vector. A mask input gates that vector onto one interrupt line.

Top module: `xor_chain_engine`

## Requirements
- R1: While reset is held and after it is released, status_o is 0, mem_req_o is low, irq_cause_o is 0 and irq_o is low.
- R2: After a start pulse in the idle state, the channel reads descriptor words 0 to 13 from chain_head_i. It takes the command from word 2, the next pointer from word 3, the byte count from word 4, the destination from word 5 and source s from word 6+s.
- R3: With op_mode_i other than 2, destination word w is the XOR of word w of every source s whose command bit s is set. If command bits 7:0 are all zero, zeros are written.
- R4: With op_mode_i equal to 2 (copy), destination word w equals word w of source 0, whatever command bits 7:0 hold.
- R5: Only bits 23:0 of the byte count word are used, and it is taken as a multiple of 4. Exactly count/4 destination words are written. A count of 0 writes no destination word but still completes the descriptor.
- R6: On completion the status word of the descriptor is overwritten with 0x40000000: bit 31 (owned by engine) is cleared and bit 30 (success) is set.
- R7: Completing a descriptor sets cause bit 0 only if command bit 31 is set. A nonzero next pointer is fetched next. A zero next pointer sets cause bit 1 and returns status_o to 0.
- R8: If the fetched status word has bit 31 clear, cause bit 7 is set, status_o returns to 0, and no memory access follows the status read.
- R9: A pause pulse while active takes effect right after the next destination word write. Then status_o is 2, cause bit 3 is set, and no memory request is made until a restart pulse. After the restart the chain finishes with the same results as an uninterrupted run.
- R10: A stop pulse while active or paused returns status_o to 0 once no request is pending and sets cause bit 2. The current descriptor gets no status writeback, and neither cause bit 0 nor cause bit 1 is set.
- R11: irq_o is high exactly when some bit is set in both irq_cause_o and irq_mask_i. A one in irq_clr_i clears that cause bit, but a new event on the same bit in the same cycle wins.
- R12: Start while active or paused, restart while not paused, and stop or pause while idle change no state and set no cause.
- R13: status_o reads 0 when idle, 1 when active (including while a pause is pending) and 2 when paused; 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command pulse |
| stop_i | input | 1 | Stop command pulse |
| pause_i | input | 1 | Pause command pulse |
| restart_i | input | 1 | Restart command pulse |
| op_mode_i | input | 3 | Operation: 2 copy, any other value XOR; sampled at start |
| chain_head_i | input | 32 | Byte address of the first descriptor |
| status_o | output | 2 | 0 idle, 1 active, 2 paused |
| irq_mask_i | input | 8 | Per-cause interrupt enable, 1 enables |
| irq_clr_i | input | 8 | Write-one-to-clear pulses for cause bits |
| irq_cause_o | output | 8 | Latched causes: 0 descriptor done, 1 chain end, 2 stopped, 3 paused, 7 ownership error |
| irq_o | output | 1 | Interrupt line |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata_i | input | 32 | Read data |

## Verification
The assertions take for granted that the memory side keeps its acknowledge strictly within a raised request. They also assume read data is valid in the acknowledge cycle, and that byte counts and addresses are word aligned. The stimulus answers requests from a model that acknowledges in the request cycle, or with a periodic stall, and never otherwise. Every descriptor it builds uses counts that are multiples of four and word-aligned buffers. Commands are one-cycle pulses driven between clock edges, and descriptor memory is only rewritten while status_o reads idle.

// File: rtl/xce_pkg.sv
package xce_pkg;
  localparam int unsigned DESC_WORDS = 16;
  localparam int unsigned FI_W       = $clog2(DESC_WORDS);
  localparam int unsigned W_CMD      = 2;
  localparam int unsigned W_NEXT     = 3;
  localparam int unsigned W_CNT      = 4;
  localparam int unsigned W_DST      = 5;
  localparam int unsigned W_SRC0     = 6;

  localparam int unsigned OWN_BIT    = 31;
  localparam int unsigned OK_BIT     = 30;
  localparam int unsigned EOD_EN_BIT = 31;

  localparam int unsigned CAUSE_W  = 8;
  localparam int unsigned C_EOD    = 0;
  localparam int unsigned C_EOC    = 1;
  localparam int unsigned C_STOP   = 2;
  localparam int unsigned C_PAUSE  = 3;
  localparam int unsigned C_OWN    = 7;

  localparam logic [1:0] ST_IDLE   = 2'd0;
  localparam logic [1:0] ST_ACTIVE = 2'd1;
  localparam logic [1:0] ST_PAUSED = 2'd2;

  localparam logic [2:0] MODE_COPY = 3'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_SRC_RD, S_DST_WR, S_WB, S_PAUSE
  } seq_st_e;
endpackage

// File: rtl/xce_desc_store.sv
module xce_desc_store
  import xce_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned NSRC  = 8,
  parameter int unsigned CNT_W = 24,
  localparam int unsigned WC_W = CNT_W - 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [FI_W-1:0]           idx_i,
  input  logic [W-1:0]              data_i,
  output logic [NSRC-1:0]           src_mask_o,
  output logic                      eod_en_o,
  output logic [W-1:0]              next_o,
  output logic [WC_W-1:0]           nwords_o,
  output logic [W-1:0]              dst_o,
  output logic [NSRC-1:0][W-1:0]    src_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_mask_o <= '0;
      eod_en_o   <= 1'b0;
      next_o     <= '0;
      nwords_o   <= '0;
      dst_o      <= '0;
    end else if (wr_i) begin
      unique case (idx_i)
        FI_W'(W_CMD): begin
          src_mask_o <= data_i[NSRC-1:0];
          eod_en_o   <= data_i[EOD_EN_BIT];
        end
        FI_W'(W_NEXT): next_o   <= data_i;
        FI_W'(W_CNT):  nwords_o <= data_i[CNT_W-1:2];
        FI_W'(W_DST):  dst_o    <= data_i;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      src_addr_o[g] <= '0;
      else if (wr_i && idx_i == FI_W'(W_SRC0 + g))      src_addr_o[g] <= data_i;
    end
  end
endmodule

// File: rtl/xce_accum.sv
module xce_accum #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         xor_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else if (xor_i) acc_o <= acc_o ^ data_i;
  end

  // R3: each destination word starts from an empty accumulator
  a_r3_acc_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_o == '0);
  a_r3_acc_fold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xor_i && !clr_i) |=> acc_o == ($past(acc_o) ^ $past(data_i)));
endmodule

// File: rtl/xce_irq.sv
module xce_irq #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] set_i,
  input  logic [CW-1:0] clr_i,
  input  logic [CW-1:0] mask_i,
  output logic [CW-1:0] cause_o,
  output logic          irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_o <= '0;
    else         cause_o <= (cause_o & ~clr_i) | set_i;
  end

  assign irq_o = |(cause_o & mask_i);

  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((cause_o & $past(set_i)) == $past(set_i)));
  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((cause_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/xce_seq.sv
module xce_seq
  import xce_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned NSRC   = 8,
  parameter int unsigned CNT_W  = 24,
  localparam int unsigned WC_W  = CNT_W - 2,
  localparam int unsigned SEL_W = $clog2(NSRC)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    stop_i,
  input  logic                    pause_i,
  input  logic                    restart_i,
  input  logic [2:0]              op_mode_i,
  input  logic [W-1:0]            head_i,
  output logic [1:0]              status_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [W-1:0]            mem_addr_o,
  output logic [W-1:0]            mem_wdata_o,
  input  logic                    mem_ack_i,
  input  logic                    own_bit_i,
  output logic                    st_wr_o,
  output logic [FI_W-1:0]         st_idx_o,
  input  logic [NSRC-1:0]         src_mask_i,
  input  logic                    eod_en_i,
  input  logic [W-1:0]            next_i,
  input  logic [WC_W-1:0]         nwords_i,
  input  logic [W-1:0]            dst_i,
  input  logic [NSRC-1:0][W-1:0]  src_addr_i,
  output logic                    acc_clr_o,
  output logic                    acc_xor_o,
  input  logic [W-1:0]            acc_i,
  output logic [CAUSE_W-1:0]      cause_set_o
);
  localparam int unsigned FI_LAST = W_SRC0 + NSRC - 1;

  seq_st_e          st_q, st_d, resume_q, resume_d, tgt_st;
  logic [W-1:0]     desc_q, desc_d;
  logic [FI_W-1:0]  fidx_q, fidx_d;
  logic [WC_W-1:0]  word_q, word_d;
  logic [SEL_W-1:0] src_q, src_d, tgt_src;
  logic             copy_q, copy_d, pause_q, pause_d, stop_q, stop_d;
  logic [NSRC-1:0]  eff_mask;
  logic [SEL_W:0]   first_hit, next_hit;
  logic [W-1:0]     woff;
  logic             active, last_word;

  // lowest enabled source at or above 'from'; MSB flags a hit
  function automatic logic [SEL_W:0] pick(input logic [NSRC-1:0] m, input logic [SEL_W:0] from);
    logic [SEL_W:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (m[i] && (i >= int'(from))) r = {1'b1, SEL_W'(i)};
    return r;
  endfunction

  assign eff_mask  = copy_q ? NSRC'(1) : src_mask_i;
  assign first_hit = pick(eff_mask, '0);
  assign next_hit  = pick(eff_mask, {1'b0, src_q} + 1'b1);
  assign tgt_st    = first_hit[SEL_W] ? S_SRC_RD : S_DST_WR;
  assign tgt_src   = first_hit[SEL_W-1:0];
  assign woff      = W'({word_q, 2'b00});
  assign last_word = (word_q + 1'b1) == nwords_i;
  assign active    = st_q inside {S_FETCH, S_SRC_RD, S_DST_WR, S_WB};
  assign st_idx_o  = fidx_q;

  always_comb begin
    mem_req_o   = active;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_q;
    mem_wdata_o = '0;
    unique case (st_q)
      S_FETCH:  mem_addr_o = desc_q + W'({fidx_q, 2'b00});
      S_SRC_RD: mem_addr_o = src_addr_i[src_q] + woff;
      S_DST_WR: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = dst_i + woff;
        mem_wdata_o = acc_i;
      end
      S_WB: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = W'(1) << OK_BIT;
      end
      default: ;
    endcase
  end

  always_comb begin
    st_d        = st_q;
    resume_d    = resume_q;
    desc_d      = desc_q;
    fidx_d      = fidx_q;
    word_d      = word_q;
    src_d       = src_q;
    copy_d      = copy_q;
    pause_d     = pause_q | (pause_i & active);
    stop_d      = stop_q | (stop_i & (st_q != S_IDLE));
    cause_set_o = '0;
    acc_clr_o   = 1'b0;
    acc_xor_o   = 1'b0;
    st_wr_o     = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_d   = S_FETCH;
        desc_d = head_i;
        fidx_d = '0;
        copy_d = (op_mode_i == MODE_COPY);
      end
      S_FETCH: if (mem_ack_i) begin
        st_wr_o = 1'b1;
        if (fidx_q == '0 && !own_bit_i) begin
          st_d               = S_IDLE;
          cause_set_o[C_OWN] = 1'b1;
        end else if (fidx_q == FI_W'(FI_LAST)) begin
          word_d    = '0;
          acc_clr_o = 1'b1;
          src_d     = tgt_src;
          st_d      = (nwords_i == '0) ? S_WB : tgt_st;
        end else begin
          fidx_d = fidx_q + 1'b1;
        end
      end
      S_SRC_RD: if (mem_ack_i) begin
        acc_xor_o = 1'b1;
        if (next_hit[SEL_W]) src_d = next_hit[SEL_W-1:0];
        else                 st_d  = S_DST_WR;
      end
      S_DST_WR: if (mem_ack_i) begin
        acc_clr_o = 1'b1;
        word_d    = word_q + 1'b1;
        src_d     = tgt_src;
        if (pause_q) begin
          st_d                 = S_PAUSE;
          resume_d             = last_word ? S_WB : tgt_st;
          pause_d              = 1'b0;
          cause_set_o[C_PAUSE] = 1'b1;
        end else begin
          st_d = last_word ? S_WB : tgt_st;
        end
      end
      S_WB: if (mem_ack_i) begin
        cause_set_o[C_EOD] = eod_en_i;
        if (next_i == '0) begin
          st_d               = S_IDLE;
          cause_set_o[C_EOC] = 1'b1;
        end else begin
          desc_d = next_i;
          fidx_d = '0;
          st_d   = S_FETCH;
        end
      end
      S_PAUSE: if (restart_i) st_d = resume_q;
      default: st_d = S_IDLE;
    endcase
    if (stop_q && st_q != S_IDLE && (!mem_req_o || mem_ack_i)) begin
      st_d                 = S_IDLE;
      cause_set_o[C_STOP]  = 1'b1;
      cause_set_o[C_EOD]   = 1'b0;
      cause_set_o[C_EOC]   = 1'b0;
      cause_set_o[C_PAUSE] = 1'b0;
    end
    if (st_d == S_IDLE) begin
      pause_d = 1'b0;
      stop_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      resume_q <= S_IDLE;
      desc_q   <= '0;
      fidx_q   <= '0;
      word_q   <= '0;
      src_q    <= '0;
      copy_q   <= 1'b0;
      pause_q  <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      resume_q <= resume_d;
      desc_q   <= desc_d;
      fidx_q   <= fidx_d;
      word_q   <= word_d;
      src_q    <= src_d;
      copy_q   <= copy_d;
      pause_q  <= pause_d;
      stop_q   <= stop_d;
    end
  end

  always_comb begin
    unique case (st_q)
      S_IDLE:  status_o = ST_IDLE;
      S_PAUSE: status_o = ST_PAUSED;
      default: status_o = ST_ACTIVE;
    endcase
  end

  a_r8_own_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_FETCH && fidx_q == '0 && mem_ack_i && !own_bit_i)
      |=> (status_o == ST_IDLE && !mem_req_o));
  a_r9_pause_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_PAUSE && $past(st_q) != S_PAUSE) |-> $past(st_q == S_DST_WR && mem_ack_i));
  a_r9_quiet_paused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_PAUSED) |-> !mem_req_o);
  a_r10_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && st_q != S_IDLE && (!mem_req_o || mem_ack_i)) |=> status_o == ST_IDLE);
  a_r5_word_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_DST_WR) |-> word_q < nwords_i);
  a_r13_status_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'b11);
endmodule

// File: rtl/xor_chain_engine.sv
module xor_chain_engine
  import xce_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned NSRC  = 8,
  parameter int unsigned CNT_W = 24,
  localparam int unsigned WC_W = CNT_W - 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               pause_i,
  input  logic               restart_i,
  input  logic [2:0]         op_mode_i,
  input  logic [W-1:0]       chain_head_i,
  output logic [1:0]         status_o,
  input  logic [CAUSE_W-1:0] irq_mask_i,
  input  logic [CAUSE_W-1:0] irq_clr_i,
  output logic [CAUSE_W-1:0] irq_cause_o,
  output logic               irq_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [W-1:0]       mem_addr_o,
  output logic [W-1:0]       mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [W-1:0]       mem_rdata_i
);
  logic                   st_wr;
  logic [FI_W-1:0]        st_idx;
  logic [NSRC-1:0]        src_mask;
  logic                   eod_en;
  logic [W-1:0]           next_ptr, dst_addr, acc;
  logic [WC_W-1:0]        nwords;
  logic [NSRC-1:0][W-1:0] src_addr;
  logic                   acc_clr, acc_xor;
  logic [CAUSE_W-1:0]     cause_set;

  xce_seq #(.W(W), .NSRC(NSRC), .CNT_W(CNT_W)) i_seq (
    .clk_i, .rst_ni, .start_i, .stop_i, .pause_i, .restart_i, .op_mode_i,
    .head_i      (chain_head_i),
    .status_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i,
    .own_bit_i   (mem_rdata_i[OWN_BIT]),
    .st_wr_o     (st_wr),
    .st_idx_o    (st_idx),
    .src_mask_i  (src_mask),
    .eod_en_i    (eod_en),
    .next_i      (next_ptr),
    .nwords_i    (nwords),
    .dst_i       (dst_addr),
    .src_addr_i  (src_addr),
    .acc_clr_o   (acc_clr),
    .acc_xor_o   (acc_xor),
    .acc_i       (acc),
    .cause_set_o (cause_set)
  );

  xce_desc_store #(.W(W), .NSRC(NSRC), .CNT_W(CNT_W)) i_store (
    .clk_i, .rst_ni,
    .wr_i       (st_wr),
    .idx_i      (st_idx),
    .data_i     (mem_rdata_i),
    .src_mask_o (src_mask),
    .eod_en_o   (eod_en),
    .next_o     (next_ptr),
    .nwords_o   (nwords),
    .dst_o      (dst_addr),
    .src_addr_o (src_addr)
  );

  xce_accum #(.W(W)) i_accum (
    .clk_i, .rst_ni,
    .clr_i  (acc_clr),
    .xor_i  (acc_xor),
    .data_i (mem_rdata_i),
    .acc_o  (acc)
  );

  xce_irq #(.CW(CAUSE_W)) i_irq (
    .clk_i, .rst_ni,
    .set_i   (cause_set),
    .clr_i   (irq_clr_i),
    .mask_i  (irq_mask_i),
    .cause_o (irq_cause_o),
    .irq_o
  );
endmodule

// File: tb/test_xor_chain_engine.sv
module test_xor_chain_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 0, stop = 0, pause = 0, restart = 0;
  logic [2:0]  mode = 3'd0;
  logic [31:0] head = 32'h100;
  logic [1:0]  status;
  logic [7:0]  imask = 8'hFF, iclr = 8'h00, cause;
  logic        irq;
  logic        req, we, ack;
  logic [31:0] addr, wdata, rdata;
  logic        stall_en = 1'b0;
  int          cyc = 0, nreq = 0;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  logic        tb_we = 1'b0;
  logic [9:0]  tb_wa;
  logic [31:0] tb_wd;
  logic [31:0] mem [0:1023];

  always #4 clk = ~clk;

  xor_chain_engine i_xor_chain_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .pause_i(pause),
    .restart_i(restart), .op_mode_i(mode), .chain_head_i(head), .status_o(status),
    .irq_mask_i(imask), .irq_clr_i(iclr), .irq_cause_o(cause), .irq_o(irq),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata));

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] src_base(input int s);
    return 32'h1000 + 32'(s) * 32'h100;
  endfunction

  function automatic logic [31:0] exp_word(input logic [7:0] m, input logic cp, input int w);
    logic [31:0] r;
    logic [7:0]  e;
    e = cp ? 8'h01 : m;
    r = '0;
    for (int s = 0; s < 8; s++) if (e[s]) r ^= pat(src_base(s) + 32'(4 * w));
    return r;
  endfunction

  assign ack   = req & ~(stall_en & cyc[1]);
  assign rdata = addr[12] ? pat(addr) : mem[addr[11:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (req && ack) nreq <= nreq + 1;
    if (tb_we) mem[tb_wa] <= tb_wd;
    else if (req && ack && we && !addr[12]) mem[addr[11:2]] <= wdata;
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_wa = a[11:2]; tb_wd = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic build(input logic [31:0] base, input logic [31:0] st, input logic [31:0] cmd,
                       input logic [31:0] nxt, input logic [31:0] cnt, input logic [31:0] dst);
    poke(base, st);
    poke(base + 4, 32'hCCCC_CCCC);
    poke(base + 8, cmd);
    poke(base + 12, nxt);
    poke(base + 16, cnt);
    poke(base + 20, dst);
    for (int s = 0; s < 8; s++) poke(base + 24 + 32'(4 * s), src_base(s));
  endtask

  task automatic fill_dst(input logic [31:0] dst, input logic [31:0] tag);
    for (int w = 0; w < 17; w++) poke(dst + 32'(4 * w), tag + 32'(w));
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: start = 1'b1; 1: stop = 1'b1; 2: pause = 1'b1; default: restart = 1'b1;
    endcase
    @(negedge clk);
    start = 1'b0; stop = 1'b0; pause = 1'b0; restart = 1'b0;
  endtask

  task automatic wait_status(input logic [1:0] want, input string rq);
    int n;
    n = 0;
    while (status !== want && n < 5000) begin @(negedge clk); n++; end
    chk(rq, 32'(status), 32'(want));
  endtask

  task automatic clear_causes;
    @(negedge clk); iclr = 8'hFF;
    @(negedge clk); iclr = 8'h00;
  endtask

  typedef struct packed {
    logic [2:0]  md;
    logic [7:0]  msk;
    logic [31:0] cnt;
    logic        eod;
  } vec_t;

  localparam vec_t VEC [0:6] = '{
    '{3'd0, 8'h01, 32'd16,         1'b1},
    '{3'd0, 8'hA5, 32'd32,         1'b1},
    '{3'd0, 8'hFF, 32'd64,         1'b0},
    '{3'd0, 8'h00, 32'd8,          1'b1},
    '{3'd2, 8'hF0, 32'd12,         1'b1},
    '{3'd5, 8'h81, 32'hFF00_0010,  1'b1},
    '{3'd0, 8'h06, 32'd0,          1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R13 watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int nw, r0;
    logic [31:0] sum;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 status in reset", 32'(status), 0);
    chk("R1 req in reset", 32'(req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cause after reset", 32'(cause), 0);
    chk("R1 irq after reset", 32'(irq), 0);

    // table walk: R2 R3 R4 R5 R6 R7 R11
    for (int v = 0; v < 7; v++) begin
      build(32'h100, 32'h8000_0000, {VEC[v].eod, 23'd0, VEC[v].msk}, 32'h0, VEC[v].cnt, 32'h400);
      fill_dst(32'h400, 32'hDEAD_0000);
      mode = VEC[v].md; head = 32'h100;
      pulse(0);
      wait_status(2'd0, "R13 idle after run");
      nw = int'(VEC[v].cnt[23:2]);
      for (int w = 0; w < nw; w++)
        chk((VEC[v].md == 3'd2) ? "R4 copy word" : "R3 xor word",
            mem[10'h100 + 10'(w)], exp_word(VEC[v].msk, VEC[v].md == 3'd2, w));
      chk("R5 word past count untouched", mem[10'h100 + 10'(nw)], 32'hDEAD_0000 + 32'(nw));
      chk("R6 status writeback", mem[10'h040], 32'h4000_0000);
      chk("R7 causes", 32'(cause), {30'd0, 1'b1, VEC[v].eod});
      chk("R11 irq with full mask", 32'(irq), 1);
      clear_causes;
      chk("R11 w1c clear", 32'(cause), 0);
    end

    // R7 chain of two with stalled memory
    build(32'h100, 32'h8000_0000, 32'h8000_0003, 32'h200, 32'd8, 32'h400);
    build(32'h200, 32'h8000_0000, 32'h0000_000C, 32'h0,   32'd8, 32'h600);
    mode = 3'd0; head = 32'h100; stall_en = 1'b1;
    pulse(0);
    pulse(0); // R12 start while active ignored
    wait_status(2'd0, "R13 chain idle");
    stall_en = 1'b0;
    chk("R7 first status", mem[10'h040], 32'h4000_0000);
    chk("R7 second status", mem[10'h080], 32'h4000_0000);
    chk("R7 first dst", mem[10'h101], exp_word(8'h03, 1'b0, 1));
    chk("R7 second dst", mem[10'h181], exp_word(8'h0C, 1'b0, 1));
    chk("R7 chain causes", 32'(cause), 32'h03);
    @(negedge clk); imask = 8'h04;
    @(negedge clk);
    chk("R11 masked irq low", 32'(irq), 0);
    imask = 8'h02;
    @(negedge clk);
    chk("R11 unmasked irq high", 32'(irq), 1);
    imask = 8'hFF;
    clear_causes;

    // R8 ownership violation
    build(32'h300, 32'h0000_0000, 32'h8000_0001, 32'h0, 32'd16, 32'h400);
    fill_dst(32'h400, 32'hBEEF_0000);
    head = 32'h300;
    @(negedge clk); r0 = nreq;
    pulse(0);
    wait_status(2'd0, "R13 idle after own error");
    chk("R8 own cause", 32'(cause), 32'h80);
    chk("R8 single access", 32'(nreq - r0), 1);
    chk("R8 status untouched", mem[10'h0C0], 32'h0);
    chk("R8 dst untouched", mem[10'h100], 32'hBEEF_0000);
    clear_causes;

    // R9 pause / restart
    build(32'h100, 32'h8000_0000, 32'h0000_000F, 32'h0, 32'd64, 32'h400);
    fill_dst(32'h400, 32'hAAAA_0000);
    head = 32'h100;
    pulse(0);
    pulse(3); // R12 restart while active ignored
    repeat (8) @(negedge clk);
    pulse(2);
    wait_status(2'd2, "R9 paused status");
    chk("R9 pause cause", 32'(cause & 8'h08), 32'h08);
    r0 = nreq;
    head = 32'h300;
    pulse(0); // R12 start while paused ignored
    repeat (4) @(negedge clk);
    chk("R9 no access while paused", 32'(nreq - r0), 0);
    chk("R12 still paused", 32'(status), 2);
    pulse(3);
    wait_status(2'd0, "R9 idle after restart");
    sum = 0;
    for (int w = 0; w < 16; w++) if (mem[10'h100 + 10'(w)] !== exp_word(8'h0F, 1'b0, w)) sum++;
    chk("R9 data after restart", sum, 0);
    chk("R9 writeback after restart", mem[10'h040], 32'h4000_0000);
    chk("R9 end causes", 32'(cause), 32'h0A);
    clear_causes;

    // R10 stop
    build(32'h100, 32'h8000_0000, 32'h8000_00FF, 32'h0, 32'd64, 32'h400);
    fill_dst(32'h400, 32'h5555_0000);
    head = 32'h100;
    pulse(0);
    repeat (20) @(negedge clk);
    pulse(1);
    wait_status(2'd0, "R10 idle after stop");
    chk("R10 stop cause only", 32'(cause), 32'h04);
    chk("R10 no writeback", mem[10'h040], 32'h8000_0000);
    chk("R10 last word untouched", mem[10'h10F], 32'h5555_000F);
    clear_causes;

    // R12 stop / pause while idle
    r0 = nreq;
    pulse(1);
    pulse(2);
    repeat (3) @(negedge clk);
    chk("R12 idle commands no cause", 32'(cause), 0);
    chk("R12 idle commands no state", 32'(status), 0);
    chk("R12 idle commands no access", 32'(nreq - r0), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule